// File: doc/BRIEF.md
# EDO Output-Drive Tracker

This block is a clocked behavioural model of the output-buffer control inside an extended-data-out DRAM. It samples the active-low row strobe, the two byte-lane column strobes, the write strobe and the output-enable strobe on a fast clock. From these samples it decides, one byte lane at a time, whether the memory's data pins would be driven. A memory controller under test is wired to its inputs, and its lane flags are compared against what the controller expects on the data bus.

The feature being modelled is that read data stays valid after the column strobe rises. Each lane therefore keeps driving through the column precharge until one of these events turns it off:
- the row strobe also rises;
- output enable is held high for long enough, measured in one of two ways depending on its level when the column strobe rose;
- a write-strobe pulse is long enough.

Once off, a lane stays off until its column strobe falls again. Every minimum pulse width is a parameter counted in sample-clock cycles. A pulse that is too short changes no state and raises a one-cycle violation flag.

Top module: `edoOutTracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, driveLo, driveHi, dataHold and violation are all 0.
- R2: When a lane's column strobe falls with rasN low and weN high, the lane starts a read. While that strobe stays low, the lane's drive flag equals the inverse of oeN sampled in the same cycle.
- R3: When a reading lane's column strobe rises while rasN and oeN are low, the lane keeps driving. dataHold is 1 whenever a lane drives while its column strobe is high.
- R4: If oeN is high in the sample where the column strobe rises, and stays high for OEHC_CYC consecutive samples counted from that sample, the lane turns off. It stays off, whatever oeN does, until its column strobe falls again.
- R5: If oeN is low when the column strobe rises, a later run of OEP_CYC consecutive high oeN samples during the strobe-high period turns the lane off. It stays off until the next fall of that strobe.
- R6: A run of WPZ_CYC consecutive low weN samples while a lane holds data turns the lane off. It stays off until the strobe falls with weN high.
- R7: A sample in which rasN and a lane's column strobe are both high turns that lane off.
- R8: A column-strobe fall with weN low starts an early write. The lane does not drive for the rest of that strobe-low period, even when oeN is low.
- R9: If weN falls while the column strobe is low and oeN is high, the cycle is a late write. The lane then stays off until its next strobe fall, even if oeN returns low.
- R10: If weN falls while the column strobe is low and oeN is low, no write takes place. The lane keeps driving.
- R11: caslN governs only driveLo (data bits 0 to 7) and cashN governs only driveHi (data bits 8 to 15).
- R12: While a lane holds data, an oeN-high run or weN-low run that ends before reaching its width leaves the lane's state unchanged. It sets violation to 1 for exactly one cycle.
- R13: A column-strobe fall while rasN is high is a refresh, not an access. The lane does not drive until a later strobe fall with rasN low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rasN | input | 1 | Row strobe, active low |
| caslN | input | 1 | Lower-lane column strobe, active low |
| cashN | input | 1 | Upper-lane column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| driveLo | output | 1 | Lower byte lane would be driven |
| driveHi | output | 1 | Upper byte lane would be driven |
| dataHold | output | 1 | A lane is driving while its column strobe is high |
| violation | output | 1 | One-cycle flag for a pulse shorter than its minimum width |

## Verification
Every output is a register updated from the same sample it reacts to, so an input change shows at the ports one clock later. A wrong lane mode or a stale lock appears as a wrong drive flag in the very next cycle after the strobe edge or pulse that should have changed it. A pulse counter that is off by one shows up either as a lock one sample early or late, or as a violation flag where a lock was due. Both are visible within one cycle of the run's end. A lock that leaks from one lane to the other is exposed by single-lane accesses that follow a word cycle.

// File: rtl/edoOutPkg.sv
package edoOutPkg;

  // Per-lane strobe events produced by the datapath for the lane control.
  typedef struct packed {
    logic casLow;   // lane column strobe active in this sample
    logic casFall;  // lane column strobe went active in this sample
    logic rasLow;   // row strobe active
    logic weLow;    // write strobe active
    logic weFall;   // write strobe went active in this sample
    logic oeLow;    // output enable active
    logic oeLock;   // output-enable high run reached its width
    logic weLock;   // write-strobe low run reached its width
    logic oeShort;  // output-enable high run ended below its width
    logic weShort;  // write-strobe low run ended below its width
  } laneEv_t;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } laneMode_t;

endpackage

// File: rtl/edoStrobeMeter.sv
module edoStrobeMeter
  import edoOutPkg::*;
#(
  parameter int LANES    = 2,
  parameter int OEHC_CYC = 2,
  parameter int OEP_CYC  = 3,
  parameter int WPZ_CYC  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic [LANES-1:0]    casN,
  input  logic                weN,
  input  logic                oeN,
  output laneEv_t [LANES-1:0] ev
);

  localparam int MAX_A   = (OEHC_CYC > OEP_CYC) ? OEHC_CYC : OEP_CYC;
  localparam int MAX_THR = (MAX_A > WPZ_CYC) ? MAX_A : WPZ_CYC;
  localparam int RUN_W   = $clog2(MAX_THR + 1);
  localparam logic [RUN_W-1:0] THR_OEHC = RUN_W'(OEHC_CYC);
  localparam logic [RUN_W-1:0] THR_OEP  = RUN_W'(OEP_CYC);
  localparam logic [RUN_W-1:0] THR_WPZ  = RUN_W'(WPZ_CYC);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(MAX_THR);

  logic prevWeLow;
  logic weLowNow;
  logic weFallNow;

  assign weLowNow  = ~weN;
  assign weFallNow = weLowNow & ~prevWeLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevWeLow <= 1'b0;
    else       prevWeLow <= weLowNow;
  end

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic             prevCasLow;
    logic             oeAtRise;
    logic [RUN_W-1:0] oeRun;
    logic [RUN_W-1:0] weRun;
    logic             casLowNow;
    logic             casRiseNow;
    logic             window;
    logic             riseFlag;
    logic [RUN_W-1:0] oeThr;
    logic [RUN_W-1:0] oeInc;
    logic [RUN_W-1:0] weInc;
    logic [RUN_W-1:0] oeRunNext;
    logic [RUN_W-1:0] weRunNext;

    always_comb begin
      casLowNow  = ~casN[l];
      casRiseNow = ~casLowNow & prevCasLow;
      window     = ~casLowNow;
      riseFlag   = casRiseNow ? oeN : oeAtRise;
      oeThr      = riseFlag ? THR_OEHC : THR_OEP;
      oeInc      = (oeRun == RUN_SAT) ? oeRun : oeRun + 1'b1;
      weInc      = (weRun == RUN_SAT) ? weRun : weRun + 1'b1;
      oeRunNext  = (window && oeN) ? oeInc : '0;
      weRunNext  = (window && weLowNow) ? weInc : '0;

      ev[l].casLow  = casLowNow;
      ev[l].casFall = casLowNow & ~prevCasLow;
      ev[l].rasLow  = ~rasN;
      ev[l].weLow   = weLowNow;
      ev[l].weFall  = weFallNow;
      ev[l].oeLow   = ~oeN;
      ev[l].oeLock  = window & oeN & (oeInc == oeThr) & (oeRun != oeThr);
      ev[l].weLock  = window & weLowNow & (weInc == THR_WPZ) & (weRun != THR_WPZ);
      ev[l].oeShort = window & ~oeN & (oeRun != '0) & (oeRun < oeThr);
      ev[l].weShort = window & ~weLowNow & (weRun != '0) & (weRun < THR_WPZ);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevCasLow <= 1'b0;
        oeAtRise   <= 1'b0;
        oeRun      <= '0;
        weRun      <= '0;
      end else begin
        prevCasLow <= casLowNow;
        oeAtRise   <= riseFlag & oeN;
        oeRun      <= oeRunNext;
        weRun      <= weRunNext;
      end
    end
  end

endmodule

// File: rtl/edoLaneCtrl.sv
module edoLaneCtrl
  import edoOutPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  laneEv_t ev,
  output logic    drive,
  output logic    hold,
  output logic    viol
);

  laneMode_t mode, modeNext;
  logic      locked, lockNext;
  logic      driveNext;
  logic      holdNext;
  logic      violNext;
  logic      inHold;

  always_comb begin
    modeNext = mode;
    lockNext = locked;
    inHold   = (mode == MODE_READ) && !locked && !ev.casLow && ev.rasLow;

    if (ev.casFall) begin
      lockNext = 1'b0;
      if (!ev.rasLow)    modeNext = MODE_IDLE;
      else if (ev.weLow) modeNext = MODE_WRITE;
      else               modeNext = MODE_READ;
    end else if (mode == MODE_READ) begin
      if (ev.casLow) begin
        if (ev.weFall && !ev.oeLow) lockNext = 1'b1;
      end else if (!ev.rasLow) begin
        lockNext = 1'b1;
      end else if (ev.oeLock || ev.weLock) begin
        lockNext = 1'b1;
      end
    end

    driveNext = (modeNext == MODE_READ) && !lockNext && ev.oeLow;
    holdNext  = driveNext && !ev.casLow;
    violNext  = inHold && (ev.oeShort || ev.weShort);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= MODE_IDLE;
      locked <= 1'b0;
      drive  <= 1'b0;
      hold   <= 1'b0;
      viol   <= 1'b0;
    end else begin
      mode   <= modeNext;
      locked <= lockNext;
      drive  <= driveNext;
      hold   <= holdNext;
      viol   <= violNext;
    end
  end

endmodule

// File: rtl/edoOutTracker.sv
module edoOutTracker
  import edoOutPkg::*;
#(
  parameter int OEHC_CYC = 2,
  parameter int OEP_CYC  = 3,
  parameter int WPZ_CYC  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rasN,
  input  logic caslN,
  input  logic cashN,
  input  logic weN,
  input  logic oeN,
  output logic driveLo,
  output logic driveHi,
  output logic dataHold,
  output logic violation
);

  localparam int LANES = 2;

  laneEv_t [LANES-1:0] ev;
  logic    [LANES-1:0] driveV;
  logic    [LANES-1:0] holdV;
  logic    [LANES-1:0] violV;

  edoStrobeMeter #(
    .LANES   (LANES),
    .OEHC_CYC(OEHC_CYC),
    .OEP_CYC (OEP_CYC),
    .WPZ_CYC (WPZ_CYC)
  ) uMeter (
    .clk (clk),
    .rstN(rstN),
    .rasN(rasN),
    .casN({cashN, caslN}),
    .weN (weN),
    .oeN (oeN),
    .ev  (ev)
  );

  for (genvar l = 0; l < LANES; l++) begin : gCtrl
    edoLaneCtrl uCtrl (
      .clk  (clk),
      .rstN (rstN),
      .ev   (ev[l]),
      .drive(driveV[l]),
      .hold (holdV[l]),
      .viol (violV[l])
    );
  end

  assign driveLo   = driveV[0];
  assign driveHi   = driveV[1];
  assign dataHold  = |holdV;
  assign violation = |violV;

endmodule

// File: rtl/edoOutTrackerChk.sv
module edoOutTrackerChk (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic caslN,
  input logic cashN,
  input logic weN,
  input logic oeN,
  input logic driveLo,
  input logic driveHi,
  input logic dataHold,
  input logic violation
);

  AST_LO_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    driveLo |-> !$past(oeN)); // R2

  AST_HI_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    driveHi |-> !$past(oeN)); // R2

  AST_HOLD_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    dataHold |-> !$past(rasN)); // R3

  AST_LO_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && caslN) |=> !driveLo); // R7

  AST_HI_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && cashN) |=> !driveHi); // R7

  AST_EARLY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && !caslN && $past(caslN) && !weN) |=> !driveLo); // R8

  AST_VIOL_IN_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> ($past(caslN) || $past(cashN))); // R12

endmodule

bind edoOutTracker edoOutTrackerChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .rasN     (rasN),
  .caslN    (caslN),
  .cashN    (cashN),
  .weN      (weN),
  .oeN      (oeN),
  .driveLo  (driveLo),
  .driveHi  (driveHi),
  .dataHold (dataHold),
  .violation(violation)
);

// File: tb/edoOutTracker_test.sv
`timescale 1ns/1ps
module edoOutTracker_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, caslN = 1'b1, cashN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic driveLo, driveHi, dataHold, violation;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  edoOutTracker #(.OEHC_CYC(2), .OEP_CYC(3), .WPZ_CYC(3)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .caslN(caslN), .cashN(cashN),
    .weN(weN), .oeN(oeN), .driveLo(driveLo), .driveHi(driveHi),
    .dataHold(dataHold), .violation(violation)
  );

  // {tag, rasN, caslN, cashN, weN, oeN, expLo, expHi, expHold, expViol}
  localparam int NV = 52;
  localparam logic [12:0] VEC [NV] = '{
    {4'd2,  5'b01111, 4'b0000}, // R2 row open, no column
    {4'd2,  5'b00010, 4'b1100}, // R2 word read
    {4'd2,  5'b00011, 4'b0000}, // R2 oe high while column low
    {4'd2,  5'b00010, 4'b1100}, // R2 oe back low
    {4'd3,  5'b01110, 4'b1110}, // R3 column rise, data held
    {4'd3,  5'b01110, 4'b1110}, // R3
    {4'd12, 5'b01111, 4'b0000}, // R12 oe high run 1 of 3
    {4'd12, 5'b01110, 4'b1111}, // R12 short run, state kept
    {4'd5,  5'b01111, 4'b0000}, // R5
    {4'd5,  5'b01111, 4'b0000}, // R5
    {4'd5,  5'b01111, 4'b0000}, // R5 third sample locks
    {4'd5,  5'b01110, 4'b0000}, // R5 stays off
    {4'd2,  5'b00010, 4'b1100}, // R2 new column fall
    {4'd4,  5'b01111, 4'b0000}, // R4 rise with oe high
    {4'd4,  5'b01111, 4'b0000}, // R4 second sample locks
    {4'd4,  5'b01110, 4'b0000}, // R4 stays off
    {4'd2,  5'b00010, 4'b1100}, // R2
    {4'd4,  5'b01111, 4'b0000}, // R4 rise with oe high
    {4'd12, 5'b01110, 4'b1111}, // R12 method-one run too short
    {4'd3,  5'b01110, 4'b1110}, // R3
    {4'd6,  5'b01100, 4'b1110}, // R6 we low run 1
    {4'd12, 5'b01110, 4'b1111}, // R12 we run too short
    {4'd6,  5'b01100, 4'b1110}, // R6
    {4'd6,  5'b01100, 4'b1110}, // R6
    {4'd6,  5'b01100, 4'b0000}, // R6 third sample locks
    {4'd6,  5'b01110, 4'b0000}, // R6 stays off
    {4'd6,  5'b00010, 4'b1100}, // R6 released by fall with we high
    {4'd3,  5'b01110, 4'b1110}, // R3
    {4'd7,  5'b11110, 4'b0000}, // R7 row and column high
    {4'd7,  5'b11110, 4'b0000}, // R7
    {4'd8,  5'b01100, 4'b0000}, // R8 row open, we low
    {4'd8,  5'b00000, 4'b0000}, // R8 early write
    {4'd8,  5'b00010, 4'b0000}, // R8 oe low ignored
    {4'd8,  5'b01110, 4'b0000}, // R8
    {4'd9,  5'b00011, 4'b0000}, // R9 read, oe high
    {4'd9,  5'b00001, 4'b0000}, // R9 late write
    {4'd9,  5'b00010, 4'b0000}, // R9 oe low ignored
    {4'd9,  5'b01110, 4'b0000}, // R9
    {4'd10, 5'b00010, 4'b1100}, // R10 read
    {4'd10, 5'b00000, 4'b1100}, // R10 we falls with oe low
    {4'd10, 5'b00010, 4'b1100}, // R10
    {4'd11, 5'b01010, 4'b1110}, // R11 lower lane rises
    {4'd11, 5'b01110, 4'b1110}, // R11
    {4'd11, 5'b00110, 4'b1110}, // R11 lower lane reads again
    {4'd11, 5'b11110, 4'b0000}, // R11 close row
    {4'd11, 5'b01110, 4'b0000}, // R11
    {4'd11, 5'b00110, 4'b1000}, // R11 lower-only access
    {4'd11, 5'b01110, 4'b1010}, // R11 lower holds, upper stays off
    {4'd13, 5'b11110, 4'b0000}, // R13
    {4'd13, 5'b10010, 4'b0000}, // R13 column fall with row high
    {4'd13, 5'b00010, 4'b0000}, // R13 row falls later
    {4'd13, 5'b11110, 4'b0000}  // R13
  };

  task automatic check(input int tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {driveLo, driveHi, dataHold, violation};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d at %0t: lo/hi/hold/viol actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] pins, input int tag, input logic [3:0] exp);
    @(negedge clk);
    {rasN, caslN, cashN, weN, oeN} = pins;
    @(posedge clk);
    #1 check(tag, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(posedge clk);
    #1 check(1, 4'b0000);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #1 check(1, 4'b0000); // R1 first cycle after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8:4], int'(VEC[i][12:9]), VEC[i][3:0]);
    end

    // R1: reset in the middle of a read clears everything
    step(5'b00010, 2, 4'b1100);
    @(negedge clk) rstN = 1'b0;
    #1 check(1, 4'b0000);
    @(negedge clk) begin
      rstN = 1'b1;
      {rasN, caslN, cashN, weN, oeN} = 5'b11111;
    end
    @(posedge clk);
    #1 check(1, 4'b0000);

    // R11: upper lane alone, lower untouched
    step(5'b01111, 11, 4'b0000);
    step(5'b01010, 11, 4'b0100);
    step(5'b01110, 11, 4'b0110);
    // R12: short oe run while only the upper lane holds
    step(5'b01111, 12, 4'b0000);
    step(5'b01110, 12, 4'b0111);
    step(5'b11110, 7, 4'b0000); // R7

    finish_run();
  end

endmodule